// File: doc/BRIEF.md
# Dual-Command Watchdog Timer

This block is a watchdog for a small processor core. A free-running prescaler first divides the system clock by four. It then divides it again by a power of two that an option selects. Each resulting tick advances a watchdog counter. When the counter passes its top value, the block raises a time-out. During normal running, the time-out produces a one-cycle reset request. While the core is halted, the time-out produces a one-cycle wake-up instead.

Software keeps the watchdog from expiring by issuing clear commands. A configuration option selects one of two clear schemes:

- **Single mode:** one plain clear command restarts the watchdog.
- **Pair mode:** two distinct clear commands, A and B, must be issued in alternation. Repeating either command has no effect.

The block keeps two status flags for the core:

- **Time-out flag:** records that the watchdog expired.
- **Power-down flag:** records that a halt command was executed.

A halt command restarts the counter and the prescaler, sets the power-down flag and puts the block into its halted state. A further option disables the watchdog entirely.

Top module: `wdg_dual_clear`

## Requirements
- R1: While `rst` is high at a clock edge, `reset_req`, `wake_up`, `flag_timeout` and `flag_powerdown` are all 0 after that edge, and the halted state and clear tracker return to idle.
- R2: The watchdog ticks once every 4·2^`opt_psc_sel` cycles. The counter is CNT_W bits wide. With no intervening restart, a time-out occurs exactly 4·2^`opt_psc_sel`·2^CNT_W clock edges after the edge that restarted it. With the default CNT_W=8 and `opt_psc_sel`=0 this is 1024 edges. The counter keeps running after a time-out, so time-outs repeat with the same period.
- R3: In single mode (`opt_pair_mode`=0), `cmd_clear` restarts the counter and prescaler and clears both flags. `cmd_clear_a` and `cmd_clear_b` have no effect, and the pair tracker is held idle.
- R4: In pair mode (`opt_pair_mode`=1), the watchdog restarts and both flags clear only when `cmd_clear_a` follows `cmd_clear_b`, or `cmd_clear_b` follows `cmd_clear_a`. A repeated command, or `cmd_clear` on its own, has no effect. After each completed pair, the tracker forgets the last command.
- R5: A time-out while not halted drives `reset_req` high for exactly one cycle, on the cycle after the expiring edge.
- R6: A time-out while halted drives `wake_up` high for one cycle instead of `reset_req`, and leaves the halted state.
- R7: `cmd_halt` restarts the counter and prescaler, sets `flag_powerdown`, clears `flag_timeout` and enters the halted state.
- R8: Every time-out sets `flag_timeout`.
- R9: With `opt_wdg_en`=0, the counter and prescaler are held at zero, and neither `reset_req` nor `wake_up` is ever raised.
- R10: When `cmd_clear_a` and `cmd_clear_b` arrive in the same cycle, both are ignored. When `cmd_halt` arrives in the same cycle as a clear, the halt takes priority: `flag_powerdown` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| opt_wdg_en | input | 1 | Option: watchdog enabled |
| opt_pair_mode | input | 1 | Option: 0 = single clear command, 1 = alternating A/B pair |
| opt_psc_sel | input | PSC_W | Option: extra prescale exponent n (division 2^n) |
| cmd_clear | input | 1 | Single-mode clear strobe |
| cmd_clear_a | input | 1 | Pair-mode clear strobe A |
| cmd_clear_b | input | 1 | Pair-mode clear strobe B |
| cmd_halt | input | 1 | Halt strobe |
| reset_req | output | 1 | One-cycle reset request on time-out while running |
| wake_up | output | 1 | One-cycle wake-up on time-out while halted |
| flag_timeout | output | 1 | Time-out status flag |
| flag_powerdown | output | 1 | Power-down status flag |

## Verification
The assertions check the following properties on every cycle:
- A reset request never lasts more than one cycle.
- A reset request and a wake-up are never raised together.
- Every request is accompanied by the time-out flag.
- A halt always leaves the flags at power-down set and time-out clear.
- A plain clear in single mode always clears both flags.
- A disabled watchdog stays silent.
- Reset forces all outputs low.

Only the bench's scenarios can show the remaining behaviour:
- The exact time-out distance for different prescale settings.
- That a repeated or simultaneous pair command leaves the timeline untouched.
- That an alternation in either order restarts the timeline at the right edge.
- That time-outs repeat with a fixed period.

These rely on a behavioural model compared on every cycle, together with cycle counts measured between commands and time-outs.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Pair-mode tracker: which clear command of the pair was seen last
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SAW_A = 2'd1,
        SEQ_SAW_B = 2'd2
    } seq_e;

    typedef struct packed {
        logic timeout;
        logic powerdown;
    } flags_t;

    typedef struct packed {
        seq_e nxt;
        logic fire;
    } seq_step_t;

    // One step of the alternation tracker; simultaneous A and B hold state
    function automatic seq_step_t seq_advance(input seq_e cur, input logic a, input logic b);
        seq_step_t r;
        r.nxt  = cur;
        r.fire = 1'b0;
        if (a && !b) begin
            if (cur == SEQ_SAW_B) begin
                r.fire = 1'b1;
                r.nxt  = SEQ_IDLE;
            end else begin
                r.nxt = SEQ_SAW_A;
            end
        end else if (b && !a) begin
            if (cur == SEQ_SAW_A) begin
                r.fire = 1'b1;
                r.nxt  = SEQ_IDLE;
            end else begin
                r.nxt = SEQ_SAW_B;
            end
        end
        return r;
    endfunction

    // Fixed divide-by-4 stage (2 bits) plus the largest selectable 2^n stage
    function automatic int unsigned pre_width(input int unsigned psc_w);
        return 2 + (1 << psc_w) - 1;
    endfunction

endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
#(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc_sel,
    output logic             tick
);
    localparam int PRE_W = pre_width(PSC_W);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] sel_mask;

    // Low (2 + n) bits of the free counter decide the tick
    always_comb sel_mask = (PRE_W'(1) << (32'(psc_sel) + 32'd2)) - PRE_W'(1);

    assign tick = run && ((pre_q & sel_mask) == sel_mask);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && tick && !restart && (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdg_clear_seq.sv
module wdg_clear_seq
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pair_mode,
    input  logic cmd_single,
    input  logic cmd_a,
    input  logic cmd_b,
    output logic fire
);
    seq_e      st_q;
    seq_step_t step;

    always_comb step = seq_advance(st_q, cmd_a, cmd_b);

    assign fire = pair_mode ? step.fire : cmd_single;

    always_ff @(posedge clk) begin
        if (rst || !pair_mode) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= step.nxt;
        end
    end
endmodule

// File: rtl/wdg_dual_clear.sv
module wdg_dual_clear
    import wdg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             opt_wdg_en,
    input  logic             opt_pair_mode,
    input  logic [PSC_W-1:0] opt_psc_sel,
    input  logic             cmd_clear,
    input  logic             cmd_clear_a,
    input  logic             cmd_clear_b,
    input  logic             cmd_halt,
    output logic             reset_req,
    output logic             wake_up,
    output logic             flag_timeout,
    output logic             flag_powerdown
);
    logic   clr_fire;
    logic   restart;
    logic   tick;
    logic   expire;
    flags_t flags_q;
    logic   halted_q;
    logic   req_q;
    logic   wake_q;

    assign restart = cmd_halt | clr_fire;

    wdg_clear_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .pair_mode  (opt_pair_mode),
        .cmd_single (cmd_clear),
        .cmd_a      (cmd_clear_a),
        .cmd_b      (cmd_clear_b),
        .fire       (clr_fire)
    );

    wdg_prescale #(.PSC_W(PSC_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (opt_wdg_en),
        .restart (restart),
        .psc_sel (opt_psc_sel),
        .tick    (tick)
    );

    wdg_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (opt_wdg_en),
        .restart (restart),
        .tick    (tick),
        .expire  (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            halted_q <= 1'b0;
            req_q    <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            req_q  <= expire && !halted_q;
            wake_q <= expire && halted_q;
            if (cmd_halt) begin
                flags_q.powerdown <= 1'b1;
                flags_q.timeout   <= 1'b0;
                halted_q          <= 1'b1;
            end else begin
                if (clr_fire) begin
                    flags_q <= '0;
                end else if (expire) begin
                    flags_q.timeout <= 1'b1;
                end
                if (expire && halted_q) begin
                    halted_q <= 1'b0;
                end
            end
        end
    end

    assign reset_req      = req_q;
    assign wake_up        = wake_q;
    assign flag_timeout   = flags_q.timeout;
    assign flag_powerdown = flags_q.powerdown;
endmodule

// File: rtl/wdg_dual_clear_chk.sv
module wdg_dual_clear_chk #(
    parameter int PSC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             opt_wdg_en,
    input logic             opt_pair_mode,
    input logic [PSC_W-1:0] opt_psc_sel,
    input logic             cmd_clear,
    input logic             cmd_clear_a,
    input logic             cmd_clear_b,
    input logic             cmd_halt,
    input logic             reset_req,
    input logic             wake_up,
    input logic             flag_timeout,
    input logic             flag_powerdown
);
    logic rst_seen;
    logic unused_ok;

    assign unused_ok = ^{opt_psc_sel, cmd_clear_a, cmd_clear_b};

    always_ff @(posedge clk) rst_seen <= rst;

    always_ff @(posedge clk) begin
        if (rst_seen === 1'b1 && !rst) begin
            AST_RESET_STATE: assert (!reset_req && !wake_up && !flag_timeout && !flag_powerdown); // R1
        end
        if (rst_seen === 1'b0 && !rst) begin
            AST_WAKE_EXCL: assert (!(reset_req && wake_up)); // R6
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req); // R5

    AST_TO_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        (reset_req || wake_up) |-> flag_timeout); // R8

    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        cmd_halt |=> (flag_powerdown && !flag_timeout)); // R7

    AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!opt_pair_mode && cmd_clear && !cmd_halt) |=> (!flag_timeout && !flag_powerdown)); // R3

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !opt_wdg_en |=> (!reset_req && !wake_up)); // R9
endmodule

bind wdg_dual_clear wdg_dual_clear_chk #(.PSC_W(PSC_W)) u_chk (.*);

// File: tb/tb_wdg_dual_clear.sv
module tb_wdg_dual_clear;
    localparam int KA = 1, KB = 2, KC = 3, KAB = 4, KH = 5, KHC = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       opt_wdg_en = 1'b1;
    logic       opt_pair_mode = 1'b0;
    logic [2:0] opt_psc_sel = 3'd0;
    logic       cmd_clear = 1'b0, cmd_clear_a = 1'b0, cmd_clear_b = 1'b0, cmd_halt = 1'b0;
    logic       reset_req, wake_up, flag_timeout, flag_powerdown;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;

    always #5 clk = ~clk;

    wdg_dual_clear dut (
        .clk(clk), .rst(rst), .opt_wdg_en(opt_wdg_en), .opt_pair_mode(opt_pair_mode),
        .opt_psc_sel(opt_psc_sel), .cmd_clear(cmd_clear), .cmd_clear_a(cmd_clear_a),
        .cmd_clear_b(cmd_clear_b), .cmd_halt(cmd_halt), .reset_req(reset_req),
        .wake_up(wake_up), .flag_timeout(flag_timeout), .flag_powerdown(flag_powerdown)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_pre = 0, m_cnt = 0, m_seq = 0, per = 4;
    bit m_to = 0, m_pd = 0, m_halted = 0, m_req = 0, m_wake = 0;
    bit m_fire, m_restart, m_tick, m_exp;

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_seq = 0;
            m_to = 0; m_pd = 0; m_halted = 0; m_req = 0; m_wake = 0;
        end else begin
            per = 4 << opt_psc_sel;
            m_fire = 0;
            if (!opt_pair_mode) begin
                m_fire = cmd_clear;
                m_seq = 0;
            end else if (cmd_clear_a && !cmd_clear_b) begin
                if (m_seq == 2) begin m_fire = 1; m_seq = 0; end else m_seq = 1;
            end else if (cmd_clear_b && !cmd_clear_a) begin
                if (m_seq == 1) begin m_fire = 1; m_seq = 0; end else m_seq = 2;
            end
            m_restart = cmd_halt || m_fire;
            m_tick = (m_pre % per) == per - 1;
            m_exp = opt_wdg_en && !m_restart && m_tick && (m_cnt == 255);
            m_req = m_exp && !m_halted;
            m_wake = m_exp && m_halted;
            if (cmd_halt) begin
                m_pd = 1; m_to = 0; m_halted = 1;
            end else begin
                if (m_fire) begin m_to = 0; m_pd = 0; end
                else if (m_exp) m_to = 1;
                if (m_exp && m_halted) m_halted = 0;
            end
            if (!opt_wdg_en || m_restart) begin
                m_pre = 0; m_cnt = 0;
            end else begin
                if (m_tick) m_cnt = (m_cnt + 1) % 256;
                m_pre = (m_pre + 1) % 512;
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started) begin
            chk(reset_req === m_req, "R5 reset_req", int'(reset_req), int'(m_req));
            chk(wake_up === m_wake, "R6 wake_up", int'(wake_up), int'(m_wake));
            chk(flag_timeout === m_to, "R8 flag_timeout", int'(flag_timeout), int'(m_to));
            chk(flag_powerdown === m_pd, "R7 flag_powerdown", int'(flag_powerdown), int'(m_pd));
        end
    end

    task automatic drive(input int kind);
        cmd_clear   = (kind == KC) || (kind == KHC);
        cmd_clear_a = (kind == KA) || (kind == KAB);
        cmd_clear_b = (kind == KB) || (kind == KAB);
        cmd_halt    = (kind == KH) || (kind == KHC);
    endtask

    task automatic pulse(input int kind);
        drive(kind);
        @(negedge clk);
        drive(0);
    endtask

    // Counts negedges until reset_req or wake_up; optional one-cycle injection
    task automatic measure(input int inj, input int kind, input int limit,
                           output int n, output bit saw_wake);
        n = 0;
        saw_wake = 0;
        forever begin
            @(negedge clk);
            n++;
            drive(0);
            if (reset_req || wake_up) begin
                saw_wake = wake_up;
                return;
            end
            if (n >= limit) begin
                n = -1;
                return;
            end
            if (n == inj) drive(kind);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2: actual hung expected completion");
        finish_run();
    end

    initial begin
        int n;
        bit w;
        repeat (3) @(negedge clk);
        chk(!reset_req && !wake_up && !flag_timeout && !flag_powerdown, "R1 reset outputs",
            int'({reset_req, wake_up, flag_timeout, flag_powerdown}), 0);
        rst = 1'b0;

        // Single mode, basic time-out distance
        pulse(KC);
        measure(-1, 0, 5000, n, w);
        chk(n == 1024, "R2 time-out distance psc=0", n, 1024);
        chk(!w, "R5 request not wake", int'(w), 0);
        chk(flag_timeout, "R8 flag after time-out", int'(flag_timeout), 1);
        @(negedge clk);
        chk(!reset_req, "R5 one-cycle request", int'(reset_req), 0);
        measure(300, KA, 5000, n, w);
        chk(n == 1023, "R3 clear_a ignored in single mode", n, 1023);
        measure(10, KB, 5000, n, w);
        chk(n == 1024, "R3 clear_b ignored, period repeats R2", n, 1024);
        pulse(KC);
        chk(!flag_timeout && !flag_powerdown, "R3 single clear flags",
            int'({flag_timeout, flag_powerdown}), 0);
        measure(-1, 0, 5000, n, w);

        // Pair mode
        opt_pair_mode = 1'b1;
        measure(50, KC, 5000, n, w);
        chk(n == 1024, "R4 plain clear ignored in pair mode", n, 1024);
        pulse(KA);
        pulse(KB);
        chk(!flag_timeout, "R4 pair clears flag", int'(flag_timeout), 0);
        measure(-1, 0, 5000, n, w);
        chk(n == 1024, "R4 restart at A then B", n, 1024);
        measure(300, KA, 5000, n, w);
        chk(n == 1024, "R4 lone A no effect", n, 1024);
        measure(10, KA, 5000, n, w);
        chk(n == 1024, "R4 repeated A no effect", n, 1024);
        measure(100, KB, 5000, n, w);
        chk(n == 1125, "R4 B after A restarts", n, 1125);
        pulse(KB);
        measure(10, KB, 5000, n, w);
        chk(n == 1023, "R4 repeated B no effect", n, 1023);
        measure(20, KAB, 5000, n, w);
        chk(n == 1024, "R10 simultaneous A and B ignored", n, 1024);
        measure(40, KA, 5000, n, w);
        chk(n == 1065, "R4 A after B restarts", n, 1065);

        // Halt and wake
        pulse(KH);
        chk(flag_powerdown && !flag_timeout, "R7 halt flags",
            int'({flag_powerdown, flag_timeout}), 2);
        measure(-1, 0, 5000, n, w);
        chk(n == 1024 && w, "R6 wake after halt", n, 1024);
        chk(!reset_req, "R6 no reset request while halted", int'(reset_req), 0);

        opt_pair_mode = 1'b0;
        pulse(KHC);
        chk(flag_powerdown, "R10 halt wins over clear", int'(flag_powerdown), 1);
        measure(-1, 0, 5000, n, w);
        chk(n == 1024 && w, "R10 halted after halt+clear", n, 1024);
        pulse(KC);
        chk(!flag_powerdown, "R3 clear drops powerdown", int'(flag_powerdown), 0);

        // Prescale selection
        opt_psc_sel = 3'd1;
        pulse(KC);
        measure(-1, 0, 5000, n, w);
        chk(n == 2048, "R2 time-out distance psc=1", n, 2048);
        opt_psc_sel = 3'd0;

        // Disabled watchdog
        opt_wdg_en = 1'b0;
        measure(-1, 0, 3000, n, w);
        chk(n == -1, "R9 disabled never expires", n, -1);
        opt_wdg_en = 1'b1;
        measure(-1, 0, 5000, n, w);
        chk(n == 1024, "R9 re-enabled restarts from zero", n, 1024);

        // Power-up reset mid-run
        pulse(KH);
        rst = 1'b1;
        @(negedge clk);
        chk(!flag_powerdown && !flag_timeout && !reset_req && !wake_up, "R1 reset clears state",
            int'({flag_powerdown, flag_timeout, reset_req, wake_up}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule